// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a running nanosecond count for hardware timestamping. On every reference clock cycle in which counting is enabled, the count advances by a programmable step. A separate correction step can be substituted once every N cycles. This trims the effective rate up or down by a small fraction without changing the reference clock. The count can optionally fold back at a programmable period. The nanoseconds that pass the period are kept when it folds, and each fold raises a one-cycle event toward neighbouring compare logic.

Software reaches the block through a small word-addressed write/read bus. It can load the count directly, restart it from zero, and read it. A read is a two-step exchange: software first asks for a snapshot through the control word, and the value word then returns that frozen copy instead of the live count. Several timestamps can therefore be compared later against one consistent instant.

Top module: `tod_counter`

## Requirements
- R1: After reset the count and the snapshot are zero, the control word reads 0, the step word reads 0, the period word reads 0x8000_0000 and `cmp_wrap_evt` is low.
- R2: While the run bit (control bit 0) is set, each clock adds the normal step (step word bits [6:0]) to the count; while it is clear, the count holds.
- R3: When the correction word (address 3) holds M other than zero, every (M+1)-th counting cycle adds the correction step (step word bits [14:8]) instead of the normal step; with M equal to zero the correction step is never used.
- R4: With fold enabled (control bit 3), a step that makes count plus step reach or pass the period word (address 2) loads count plus step minus period. A period of 0x8000_0000 therefore gives a 31-bit count that returns through zero.
- R5: A fold drives `cmp_wrap_evt` high for exactly the one cycle after the folding edge, and only while forwarding (control bit 4) is set; with forwarding clear the fold still happens but the output stays low.
- R6: Writing control bit 2 requests a snapshot. The request clears itself after one cycle, and that next edge copies the count into the snapshot. A read of the value word (address 1) returns the snapshot, never the live count.
- R7: A write to the value word loads the count at that edge, in place of that cycle's step.
- R8: Writing control bit 1 clears the count and restarts the correction cycle so that the next correction falls M+1 counting cycles later.
- R9: With fold disabled, the count wraps modulo 2^32 and no event is raised.
- R10: Register addresses: control 0, value 1, period 2, correction 3, step 4. The control word reads back bits 0, 3 and 4 and returns zero in bits 1 and 2. The step word reads back both step fields in their positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmp_wrap_evt | output | 1 | One-cycle fold event for compare logic |

## Verification
The hardest situations to reach from the ports are the edges where two rules meet. One is a fold that lands exactly on the period, so the count must become zero. Another is a fold that starts just below 0x8000_0000 after a direct load. A third is a correction phase that has to be reset in the middle of a run. The stimulus gets to each one deterministically. It loads the count through the value word, or restarts it, and then enables counting for an exact number of edges before stopping. Every result is read back through a snapshot, and it is compared against a cycle-by-cycle reference model of steps, corrections and folds.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_VALUE  = 3'd1,
      REG_PERIOD = 3'd2,
      REG_CORR   = 3'd3,
      REG_STEP   = 3'd4
   } tod_reg_e;

   localparam int unsigned CB_RUN     = 0;
   localparam int unsigned CB_RESTART = 1;
   localparam int unsigned CB_SNAP    = 2;
   localparam int unsigned CB_FOLD    = 3;
   localparam int unsigned CB_FWD     = 4;

   localparam int unsigned CORR_LSB   = 8;
endpackage

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
   import tod_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned STEP_W     = 7,
   parameter int unsigned CORR_W     = 32,
   parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(32'h8000_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  snapshot,
   output logic              run,
   output logic              fold_en,
   output logic              fwd_en,
   output logic              restart,
   output logic              snap_req,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  period,
   output logic [CORR_W-1:0] corr_per,
   output logic [STEP_W-1:0] step_norm,
   output logic [STEP_W-1:0] step_corr
);
   logic wr_ctrl;

   assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
   assign restart  = wr_ctrl && bus_wdata[CB_RESTART];
   assign load     = bus_wr && (bus_addr == REG_VALUE);
   assign load_val = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         fold_en   <= 1'b0;
         fwd_en    <= 1'b0;
         snap_req  <= 1'b0;
         period    <= PERIOD_RST;
         corr_per  <= '0;
         step_norm <= '0;
         step_corr <= '0;
      end else begin
         snap_req <= wr_ctrl && bus_wdata[CB_SNAP];
         if (wr_ctrl) begin
            run     <= bus_wdata[CB_RUN];
            fold_en <= bus_wdata[CB_FOLD];
            fwd_en  <= bus_wdata[CB_FWD];
         end
         if (bus_wr && (bus_addr == REG_PERIOD)) period   <= bus_wdata[CNT_W-1:0];
         if (bus_wr && (bus_addr == REG_CORR))   corr_per <= bus_wdata[CORR_W-1:0];
         if (bus_wr && (bus_addr == REG_STEP)) begin
            step_norm <= bus_wdata[STEP_W-1:0];
            step_corr <= bus_wdata[CORR_LSB +: STEP_W];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CB_RUN]  = run;
            bus_rdata[CB_FOLD] = fold_en;
            bus_rdata[CB_FWD]  = fwd_en;
         end
         REG_VALUE:  bus_rdata = 32'(snapshot);
         REG_PERIOD: bus_rdata = 32'(period);
         REG_CORR:   bus_rdata = 32'(corr_per);
         REG_STEP: begin
            bus_rdata[STEP_W-1:0]          = step_norm;
            bus_rdata[CORR_LSB +: STEP_W]  = step_corr;
         end
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tod_rate.sv
`timescale 1ns/1ps
module tod_rate #(
   parameter int unsigned STEP_W = 7,
   parameter int unsigned CORR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [CORR_W-1:0] corr_per,
   input  logic [STEP_W-1:0] step_norm,
   input  logic [STEP_W-1:0] step_corr,
   output logic [STEP_W-1:0] step
);
   logic [CORR_W-1:0] phase;
   logic              hit;

   assign hit  = (corr_per != '0) && (phase >= corr_per);
   assign step = hit ? step_corr : step_norm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (run)     phase <= hit ? '0 : phase + 1'b1;
   end
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum #(
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned STEP_W       = 7,
   parameter bit          KEEP_RESIDUE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [STEP_W-1:0] step,
   input  logic              fold_en,
   input  logic [CNT_W-1:0]  period,
   input  logic              snap_req,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  snapshot,
   output logic              fold_evt
);
   localparam int unsigned SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] folded;
   logic             fold_hit;

   assign sum      = {1'b0, count} + SUM_W'(step);
   assign fold_hit = run && fold_en && (sum >= {1'b0, period});

   if (KEEP_RESIDUE) begin : g_residue
      assign folded = sum - {1'b0, period};
   end else begin : g_zero
      assign folded = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         snapshot <= '0;
         fold_evt <= 1'b0;
      end else begin
         fold_evt <= fold_hit && !restart && !load;
         if (snap_req) snapshot <= count;
         if (restart)        count <= '0;
         else if (load)      count <= load_val;
         else if (run)       count <= fold_hit ? folded[CNT_W-1:0] : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
   import tod_pkg::*;
#(
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned STEP_W       = 7,
   parameter int unsigned CORR_W       = 32,
   parameter bit          KEEP_RESIDUE = 1'b1,
   parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(32'h8000_0000)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        cmp_wrap_evt
);
   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
      $error("tod_counter: CNT_W must lie in 8..32");
   end
   if (STEP_W < 1 || STEP_W > CORR_LSB) begin : g_bad_step
      $error("tod_counter: STEP_W must lie in 1..8");
   end
   if (CORR_W < 1 || CORR_W > 32) begin : g_bad_corr
      $error("tod_counter: CORR_W must lie in 1..32");
   end

   logic              run, fold_en, fwd_en, restart, snap_req, load;
   logic [CNT_W-1:0]  load_val, period, count, snapshot;
   logic [CORR_W-1:0] corr_per;
   logic [STEP_W-1:0] step_norm, step_corr, step;
   logic              fold_evt;

   tod_regs #(
      .CNT_W(CNT_W), .STEP_W(STEP_W), .CORR_W(CORR_W), .PERIOD_RST(PERIOD_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snapshot(snapshot),
      .run(run), .fold_en(fold_en), .fwd_en(fwd_en), .restart(restart),
      .snap_req(snap_req), .load(load), .load_val(load_val), .period(period),
      .corr_per(corr_per), .step_norm(step_norm), .step_corr(step_corr)
   );

   tod_rate #(.STEP_W(STEP_W), .CORR_W(CORR_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .corr_per(corr_per), .step_norm(step_norm), .step_corr(step_corr),
      .step(step)
   );

   tod_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W), .KEEP_RESIDUE(KEEP_RESIDUE)) u_accum (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .load(load),
      .load_val(load_val), .step(step), .fold_en(fold_en), .period(period),
      .snap_req(snap_req), .count(count), .snapshot(snapshot), .fold_evt(fold_evt)
   );

   assign cmp_wrap_evt = fold_evt && fwd_en;
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk
   import tod_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             run,
   input logic             fold_en,
   input logic             snap_req,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] snapshot,
   input logic             cmp_wrap_evt
);
   logic wr_value, wr_restart;
   assign wr_value   = bus_wr && (bus_addr == REG_VALUE);
   assign wr_restart = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[CB_RESTART];

   // R2
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_value && !wr_restart) |=> $stable(count));

   // R4
   fold_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wrap_evt |-> $past(fold_en));

   // R6
   snap_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> !snap_req);

   // R6
   snap_takes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snapshot == $past(count)));

   // R6
   snap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snapshot));

   // R7
   load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_value |=> (count == $past(bus_wdata[CNT_W-1:0])));

   // R8
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_restart |=> (count == '0));
endmodule

bind tod_counter tod_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .run(run), .fold_en(fold_en), .snap_req(snap_req),
   .count(count), .snapshot(snapshot), .cmp_wrap_evt(cmp_wrap_evt)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
   localparam logic [31:0] B_RUN  = 32'h01;
   localparam logic [31:0] B_RST  = 32'h02;
   localparam logic [31:0] B_SNAP = 32'h04;
   localparam logic [31:0] B_FOLD = 32'h08;
   localparam logic [31:0] B_FWD  = 32'h10;
   localparam logic [2:0] A_CTRL = 3'd0, A_VAL = 3'd1, A_PER = 3'd2,
                          A_CORR = 3'd3, A_STEP = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cmp_wrap_evt;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tod_counter dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_wrap_evt(cmp_wrap_evt)
   );

   always @(negedge clk) if (cmp_wrap_evt) pulses++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic capture(input logic [31:0] bits, output logic [31:0] d);
      wr(A_CTRL, bits | B_SNAP);
      @(posedge clk);
      rd(A_VAL, d);
   endtask

   task automatic run_cycles(input int k, input logic [31:0] bits);
      wr(A_CTRL, bits | B_RUN);
      repeat (k - 1) @(posedge clk);
      wr(A_CTRL, bits & ~(B_RUN | B_RST));
   endtask

   function automatic logic [31:0] model(input logic [31:0] start, input int k,
         input int stp, input int cstp, input int m, input bit fold, input logic [31:0] per);
      longint c = longint'(start);
      int ph = 0;
      for (int i = 0; i < k; i++) begin
         bit hit = (m != 0) && (ph == m);
         c = c + (hit ? cstp : stp);
         ph = hit ? 0 : ph + 1;
         if (fold && c >= longint'(per)) c = c - longint'(per);
         else c = c & 64'hFFFF_FFFF;
      end
      return c[31:0];
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(A_CTRL, d);  check("R1 ctrl", d, 32'h0);
      rd(A_VAL, d);   check("R1 snapshot", d, 32'h0);
      rd(A_PER, d);   check("R1 period", d, 32'h8000_0000);
      rd(A_STEP, d);  check("R1 step", d, 32'h0);
      check("R1 event", {31'b0, cmp_wrap_evt}, 32'h0);
   endtask

   task automatic t_plain();
      logic [31:0] d;
      wr(A_STEP, 32'd8); wr(A_CORR, 32'd0);
      run_cycles(12, B_RST);
      capture(32'h0, d); check("R2 run 12", d, model(0, 12, 8, 0, 0, 0, 0));
      repeat (5) @(posedge clk);
      capture(32'h0, d); check("R2 hold", d, 32'd96);
   endtask

   task automatic t_corr();
      logic [31:0] d;
      wr(A_STEP, 32'd8 | (32'd9 << 8)); wr(A_CORR, 32'd3);
      run_cycles(10, B_RST);
      capture(32'h0, d); check("R3 up trim", d, model(0, 10, 8, 9, 3, 0, 0));
      wr(A_STEP, 32'd8 | (32'd7 << 8)); wr(A_CORR, 32'd1);
      run_cycles(6, B_RST);
      capture(32'h0, d); check("R3 down trim", d, 32'd45);
      wr(A_CORR, 32'd0);
      run_cycles(6, B_RST);
      capture(32'h0, d); check("R3 zero period", d, 32'd48);
   endtask

   task automatic t_restart();
      logic [31:0] d;
      wr(A_STEP, 32'd8 | (32'd9 << 8)); wr(A_CORR, 32'd3);
      wr(A_CTRL, B_RUN | B_RST);
      repeat (5) @(posedge clk);
      run_cycles(10, B_RST);
      capture(32'h0, d); check("R8 restart phase", d, 32'd82);
      wr(A_CORR, 32'd0);
   endtask

   task automatic t_fold();
      logic [31:0] d;
      wr(A_STEP, 32'd7); wr(A_PER, 32'd100);
      pulses = 0;
      run_cycles(20, B_RST | B_FOLD | B_FWD);
      repeat (2) @(posedge clk);
      capture(B_FOLD | B_FWD, d); check("R4 residue", d, model(0, 20, 7, 0, 0, 1, 100));
      check("R5 one pulse", pulses, 32'd1);
      wr(A_PER, 32'd70);
      pulses = 0;
      run_cycles(10, B_RST | B_FOLD | B_FWD);
      repeat (2) @(posedge clk);
      capture(B_FOLD | B_FWD, d); check("R4 exact period", d, 32'd0);
      check("R5 exact pulse", pulses, 32'd1);
      wr(A_PER, 32'd100);
      pulses = 0;
      run_cycles(20, B_RST | B_FOLD);
      repeat (2) @(posedge clk);
      capture(B_FOLD, d); check("R5 no forward value", d, 32'd40);
      check("R5 no forward pulse", pulses, 32'd0);
   endtask

   task automatic t_boundary();
      logic [31:0] d;
      wr(A_STEP, 32'd8); wr(A_PER, 32'h8000_0000);
      wr(A_VAL, 32'h7FFF_FFF0);
      pulses = 0;
      run_cycles(3, B_FOLD | B_FWD);
      repeat (2) @(posedge clk);
      capture(B_FOLD | B_FWD, d); check("R4 31-bit fold", d, 32'd8);
      check("R4 31-bit pulse", pulses, 32'd1);
      wr(A_VAL, 32'h7FFF_FFF0);
      pulses = 0;
      run_cycles(3, 32'h0);
      repeat (2) @(posedge clk);
      capture(32'h0, d); check("R9 no fold", d, 32'h8000_0008);
      check("R9 no pulse", pulses, 32'd0);
      wr(A_VAL, 32'hFFFF_FFF8);
      run_cycles(3, 32'h0);
      capture(32'h0, d); check("R9 mod 2^32", d, model(32'hFFFF_FFF8, 3, 8, 0, 0, 0, 0));
   endtask

   task automatic t_capture();
      logic [31:0] d;
      wr(A_STEP, 32'd7);
      wr(A_VAL, 32'h1234);
      capture(32'h0, d); check("R6 snapshot", d, 32'h1234);
      run_cycles(5, 32'h0);
      rd(A_VAL, d); check("R6 not live", d, 32'h1234);
      capture(32'h0, d); check("R6 new snapshot", d, 32'h1234 + 32'd35);
   endtask

   task automatic t_load();
      logic [31:0] d;
      wr(A_STEP, 32'd7);
      wr(A_CTRL, B_RUN | B_RST);
      repeat (3) @(posedge clk);
      wr(A_VAL, 32'h5000);
      wr(A_CTRL, 32'h0);
      capture(32'h0, d); check("R7 load while running", d, 32'h5007);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(A_STEP, 32'hFFFF_FFFF);
      rd(A_STEP, d); check("R10 step fields", d, 32'h0000_7F7F);
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, d); check("R10 ctrl readback", d, 32'h0000_0019);
      wr(A_CTRL, 32'h0);
      wr(A_CORR, 32'd5);
      rd(A_CORR, d); check("R10 corr readback", d, 32'd5);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_plain();
      t_corr();
      t_restart();
      t_fold();
      t_boundary();
      t_capture();
      t_load();
      t_regs();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule